// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is a trace sink. It takes 32-bit trace words from a valid/ready stream and writes them into an internal circular RAM. A small register bus (address, write strobe, read strobe, write data, registered read data) programs it. Software starts and stops capture with an enable bit. Software can also arm a post-trigger countdown that ends capture a set number of words after a trigger. A self-clearing flush request pads the current partial frame with zero words up to the frame boundary. After the flush the block can report itself stopped.

Software reaches the RAM only through pointer registers and two data ports. A write to the data-in port stores a word at the write pointer and advances that pointer. A read of the data-out port returns the word at the read pointer and advances that pointer. Both pointers wrap at the RAM depth. This lets software clear, preload and drain the buffer.

The trace stream follows the valid/ready rules. A word transfers on a clock edge where `trc_valid` and `trc_ready` are both high. `trc_ready` does not depend on `trc_valid`. A source that sees `trc_ready` low must hold its word until ready returns. `trc_trigger` qualifies the word it travels with. Ready is high only while capture is enabled, the block is not stopped and no flush is pending.

Top module: `tracebuf_top`

## Requirements
- R1: `trc_ready` is 1 only while capture-enable (control register 0x018 bit 0) is set, the stopped flag is clear and no flush is pending. It falls in the cycle after a write of 0 to the enable bit. The stopped flag (formatter status 0x100 bit 1) becomes 1 one cycle after that. Writing 1 while the enable bit is clear restarts capture.
- R2: Each accepted trace word is stored at the write pointer (0x010). The pointer then advances by one and wraps from DEPTH-1 to 0.
- R3: Status register 0x004 bit 0 (wrapped) is set when capture or padding writes entry DEPTH-1. It is cleared when capture is restarted.
- R4: A write to the data-in port (0x01C) stores the word at the write pointer and advances the pointer. The write is ignored while capture is running (enabled and not stopped) or while a flush is pending.
- R5: A read of the data-out port (0x008) returns, one cycle later on `reg_rdata`, the word at the read pointer (0x00C). The read pointer then advances by one, wrapping at DEPTH.
- R6: When stop-on-trigger (formatter control 0x104 bit 3) is set, the first word flagged by `trc_trigger` is stored. Exactly N more words are then accepted, where N is the value in trigger count register 0x014. After that `trc_ready` stays low and the stopped flag is set.
- R7: Status bit 1 reports that a trigger was seen and status bit 2 reports that the post-trigger count has finished. With stop-on-trigger clear, capture continues after the count finishes.
- R8: Setting the flush request (0x104 bit 1) holds `trc_ready` low. If formatting is enabled (0x104 bit 0) and the write pointer is not a multiple of FRAME, one zero word is written per cycle until it is. The request bit then clears itself. Formatter status 0x100 bit 0 mirrors the pending flush.
- R9: With formatting disabled, a flush writes no padding and clears itself in the cycle after the request.
- R10: With stop-on-flush (0x104 bit 2) set, the stopped flag is set when a flush completes. With it clear, capture resumes after the flush.
- R11: Register 0x000 reads DEPTH. The pointer, trigger count, control and formatter control registers read back what was written, except the flush bit, which reads as the pending flush.
- R12: After reset, capture is disabled, the block is stopped (0x100 reads 2), both pointers, the status and the formatter control read 0, and `trc_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (data-out port advances on it) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_rd` |
| trc_valid | input | 1 | Trace word valid |
| trc_ready | output | 1 | Block accepts the trace word |
| trc_data | input | 32 | Trace word |
| trc_trigger | input | 1 | Trigger flag for the current trace word |

## Verification
A wrong write pointer shows up on the first readback through the data-out port: a word lands in the wrong slot, a word is missing, or the pointer register reads the wrong value one read after the fault. Trigger-countdown errors show on `trc_ready` at the very edge where the Nth post-trigger word should have been the last one. Flush faults show as nonzero words left in the padded slots or as a request bit that never clears. A stopped flag that is wrong shows on `trc_ready` in the next cycle, and in formatter status on the following register read.

// File: rtl/tracebuf_pkg.sv
package tracebuf_pkg;

  localparam int unsigned REG_AW = 12;

  localparam logic [REG_AW-1:0] OFF_DEPTH   = 12'h000;
  localparam logic [REG_AW-1:0] OFF_STATUS  = 12'h004;
  localparam logic [REG_AW-1:0] OFF_RDATA   = 12'h008;
  localparam logic [REG_AW-1:0] OFF_RPTR    = 12'h00C;
  localparam logic [REG_AW-1:0] OFF_WPTR    = 12'h010;
  localparam logic [REG_AW-1:0] OFF_TRIG    = 12'h014;
  localparam logic [REG_AW-1:0] OFF_CTRL    = 12'h018;
  localparam logic [REG_AW-1:0] OFF_WDATA   = 12'h01C;
  localparam logic [REG_AW-1:0] OFF_FMTSTAT = 12'h100;
  localparam logic [REG_AW-1:0] OFF_FMTCTRL = 12'h104;

  // formatter control bit positions
  localparam int unsigned FC_FMT_EN     = 0;
  localparam int unsigned FC_FLUSH      = 1;
  localparam int unsigned FC_STOP_FLUSH = 2;
  localparam int unsigned FC_STOP_TRIG  = 3;

  typedef struct packed {
    logic fmt_en;
    logic stop_flush;
    logic stop_trig;
  } fmt_cfg_t;

endpackage

// File: rtl/tracebuf_ram.sv
module tracebuf_ram #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/tracebuf_regs.sv
module tracebuf_regs
  import tracebuf_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 32,
  parameter int unsigned CW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  // state from the capture sequencer and RAM
  input  logic [AW-1:0]     wptr,
  input  logic              full,
  input  logic              trig_seen,
  input  logic              trig_done,
  input  logic              stopped,
  input  logic              flush_done,
  input  logic [DW-1:0]     ram_rdata,
  // controls
  output logic              cap_en,
  output logic              cap_start,
  output fmt_cfg_t          cfg,
  output logic              flush_pend,
  output logic [CW-1:0]     trig_cnt,
  output logic [AW-1:0]     rptr,
  output logic              wptr_ld,
  output logic [AW-1:0]     wptr_ld_val,
  output logic              sw_wr,
  output logic [DW-1:0]     sw_wdata
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic wr_ctrl, wr_fc, wr_trig, wr_rptr, rd_port;
  logic [DW-1:0] rd_mux;

  assign wr_ctrl = reg_wr && (reg_addr == OFF_CTRL);
  assign wr_fc   = reg_wr && (reg_addr == OFF_FMTCTRL);
  assign wr_trig = reg_wr && (reg_addr == OFF_TRIG);
  assign wr_rptr = reg_wr && (reg_addr == OFF_RPTR);
  assign rd_port = reg_rd && (reg_addr == OFF_RDATA);

  assign cap_start   = wr_ctrl && reg_wdata[0] && !cap_en;
  assign wptr_ld     = reg_wr && (reg_addr == OFF_WPTR);
  assign wptr_ld_val = reg_wdata[AW-1:0];
  assign sw_wr       = reg_wr && (reg_addr == OFF_WDATA);
  assign sw_wdata    = reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_en     <= 1'b0;
      cfg        <= '0;
      flush_pend <= 1'b0;
      trig_cnt   <= '0;
    end else begin
      if (wr_ctrl) cap_en <= reg_wdata[0];
      if (wr_trig) trig_cnt <= reg_wdata[CW-1:0];
      if (wr_fc) begin
        cfg.fmt_en     <= reg_wdata[FC_FMT_EN];
        cfg.stop_flush <= reg_wdata[FC_STOP_FLUSH];
        cfg.stop_trig  <= reg_wdata[FC_STOP_TRIG];
      end
      if (wr_fc && reg_wdata[FC_FLUSH]) flush_pend <= 1'b1;
      else if (flush_done)              flush_pend <= 1'b0;
    end
  end

  // read pointer: a software load wins over the port advance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rptr <= '0;
    else if (wr_rptr) rptr <= reg_wdata[AW-1:0];
    else if (rd_port) rptr <= (rptr == LAST) ? '0 : rptr + AW'(1);
  end

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr)
      OFF_DEPTH:   rd_mux = DW'(DEPTH);
      OFF_STATUS:  rd_mux = DW'({trig_done, trig_seen, full});
      OFF_RDATA:   rd_mux = ram_rdata;
      OFF_RPTR:    rd_mux = DW'(rptr);
      OFF_WPTR:    rd_mux = DW'(wptr);
      OFF_TRIG:    rd_mux = DW'(trig_cnt);
      OFF_CTRL:    rd_mux = DW'(cap_en);
      OFF_FMTSTAT: rd_mux = DW'({stopped, flush_pend});
      OFF_FMTCTRL: rd_mux = DW'({cfg.stop_trig, cfg.stop_flush, flush_pend, cfg.fmt_en});
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

endmodule

// File: rtl/tracebuf_seq.sv
module tracebuf_seq
  import tracebuf_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 32,
  parameter int unsigned CW    = 32,
  parameter int unsigned FRAME = 4,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned FW   = (FRAME > 1) ? $clog2(FRAME) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic          cap_start,
  input  fmt_cfg_t      cfg,
  input  logic          flush_pend,
  input  logic [CW-1:0] trig_cnt,
  input  logic          wptr_ld,
  input  logic [AW-1:0] wptr_ld_val,
  input  logic          sw_wr,
  input  logic [DW-1:0] sw_wdata,
  input  logic          trc_valid,
  input  logic [DW-1:0] trc_data,
  input  logic          trc_trigger,
  output logic          trc_ready,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [DW-1:0] ram_wdata,
  output logic [AW-1:0] wptr,
  output logic          full,
  output logic          trig_seen,
  output logic          trig_done,
  output logic          stopped,
  output logic          flush_done
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic running, beat, aligned, pad_now, sw_take, capt_adv;
  logic first_trig, trig_fin, cd_act;
  logic [CW-1:0] remain;

  if (FRAME > 1) begin : g_frame
    assign aligned = (wptr[FW-1:0] == '0);
  end else begin : g_noframe
    assign aligned = 1'b1;
  end

  assign running    = cap_en && !stopped;
  assign trc_ready  = running && !flush_pend;
  assign beat       = trc_valid && trc_ready;
  assign pad_now    = flush_pend && cfg.fmt_en && !aligned;
  assign flush_done = flush_pend && !pad_now;
  assign sw_take    = sw_wr && !running && !flush_pend;
  assign capt_adv   = pad_now || beat;

  assign ram_we    = capt_adv || sw_take;
  assign ram_waddr = wptr;
  assign ram_wdata = pad_now ? '0 : (beat ? trc_data : sw_wdata);

  assign first_trig = trc_trigger && !trig_seen;
  assign trig_fin   = beat && ((first_trig && (trig_cnt == '0)) ||
                               (cd_act && (remain == CW'(1))));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wptr <= '0;
    else if (wptr_ld) wptr <= wptr_ld_val;
    else if (ram_we)  wptr <= (wptr == LAST) ? '0 : wptr + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         full <= 1'b0;
    else if (cap_start)                 full <= 1'b0;
    else if (capt_adv && wptr == LAST)  full <= 1'b1;
  end

  // post-trigger countdown
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_seen <= 1'b0;
      trig_done <= 1'b0;
      cd_act    <= 1'b0;
      remain    <= '0;
    end else if (cap_start) begin
      trig_seen <= 1'b0;
      trig_done <= 1'b0;
      cd_act    <= 1'b0;
    end else if (beat) begin
      if (first_trig) begin
        trig_seen <= 1'b1;
        if (trig_cnt == '0) trig_done <= 1'b1;
        else begin
          cd_act <= 1'b1;
          remain <= trig_cnt;
        end
      end else if (cd_act) begin
        remain <= remain - CW'(1);
        if (remain == CW'(1)) begin
          cd_act    <= 1'b0;
          trig_done <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  stopped <= 1'b1;
    else if (cap_start)                          stopped <= 1'b0;
    else if (!cap_en && !flush_pend)             stopped <= 1'b1;
    else if ((flush_done && cfg.stop_flush) ||
             (trig_fin && cfg.stop_trig))        stopped <= 1'b1;
  end

endmodule

// File: rtl/tracebuf_top.sv
module tracebuf_top
  import tracebuf_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned FRAME = 4,
  parameter int unsigned CW    = 32,
  localparam int unsigned DW   = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              trc_valid,
  output logic              trc_ready,
  input  logic [DW-1:0]     trc_data,
  input  logic              trc_trigger
);

  fmt_cfg_t      cfg;
  logic          cap_en, cap_start, flush_pend, flush_done;
  logic          full, trig_seen, trig_done, stopped;
  logic [CW-1:0] trig_cnt;
  logic [AW-1:0] rptr, wptr, wptr_ld_val, ram_waddr;
  logic          wptr_ld, sw_wr, ram_we;
  logic [DW-1:0] sw_wdata, ram_wdata, ram_rdata;

  tracebuf_regs #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_regs (
    .clk, .rst_n, .reg_addr, .reg_wr, .reg_rd, .reg_wdata, .reg_rdata,
    .wptr, .full, .trig_seen, .trig_done, .stopped, .flush_done, .ram_rdata,
    .cap_en, .cap_start, .cfg, .flush_pend, .trig_cnt, .rptr,
    .wptr_ld, .wptr_ld_val, .sw_wr, .sw_wdata
  );

  tracebuf_seq #(.DEPTH(DEPTH), .DW(DW), .CW(CW), .FRAME(FRAME)) u_seq (
    .clk, .rst_n, .cap_en, .cap_start, .cfg, .flush_pend, .trig_cnt,
    .wptr_ld, .wptr_ld_val, .sw_wr, .sw_wdata,
    .trc_valid, .trc_data, .trc_trigger, .trc_ready,
    .ram_we, .ram_waddr, .ram_wdata,
    .wptr, .full, .trig_seen, .trig_done, .stopped, .flush_done
  );

  tracebuf_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk, .wr_en(ram_we), .wr_addr(ram_waddr), .wr_data(ram_wdata),
    .rd_addr(rptr), .rd_data(ram_rdata)
  );

endmodule

// File: rtl/tracebuf_chk.sv
module tracebuf_chk
  import tracebuf_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned FRAME = 4,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_AW-1:0] reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic              reg_wdata0,
  input logic              trc_valid,
  input logic              trc_ready,
  input logic [AW-1:0]     wptr,
  input logic [AW-1:0]     rptr,
  input logic              full,
  input logic              trig_done,
  input logic              stopped,
  input logic              flush_pend,
  input logic              fmt_en,
  input logic              stop_flush,
  input logic              stop_trig
);

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  logic beat, ld_w, ld_r, wr_ctl;
  assign beat   = trc_valid && trc_ready;
  assign ld_w   = reg_wr && (reg_addr == OFF_WPTR);
  assign ld_r   = reg_wr && (reg_addr == OFF_RPTR);
  assign wr_ctl = reg_wr && (reg_addr == OFF_CTRL);

  AST_DISABLE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !reg_wdata0) |=> !trc_ready);  // R1

  AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !ld_w) |=> (wptr == step($past(wptr))));  // R2

  AST_FULL_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && wptr == AW'(DEPTH - 1)) |=> full);  // R3

  AST_RPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == OFF_RDATA && !ld_r) |=> (rptr == step($past(rptr))));  // R5

  AST_TRIG_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(trig_done) && stop_trig) |-> !trc_ready);  // R6

  AST_FLUSH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(flush_pend) && fmt_en && $past(fmt_en) && !$past(ld_w))
      |-> ((32'(wptr) % FRAME) == 0));  // R8

  AST_STOP_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(flush_pend) && stop_flush && !$past(wr_ctl)) |-> stopped);  // R10

endmodule

bind tracebuf_top tracebuf_chk #(.DEPTH(DEPTH), .FRAME(FRAME)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .reg_wdata0(reg_wdata[0]), .trc_valid(trc_valid),
  .trc_ready(trc_ready), .wptr(wptr), .rptr(rptr), .full(full),
  .trig_done(trig_done), .stopped(stopped), .flush_pend(flush_pend),
  .fmt_en(cfg.fmt_en), .stop_flush(cfg.stop_flush), .stop_trig(cfg.stop_trig)
);

// File: tb/test_tracebuf_top.sv
`timescale 1ns/1ps
module test_tracebuf_top;
  import tracebuf_pkg::*;

  localparam int unsigned DEPTH = 16;
  localparam int unsigned FRAME = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        trc_valid = 1'b0;
  logic        trc_ready;
  logic [31:0] trc_data = '0;
  logic        trc_trigger = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tracebuf_top #(.DEPTH(DEPTH), .FRAME(FRAME)) i_tracebuf_top (
    .clk, .rst_n, .reg_addr, .reg_wr, .reg_rd, .reg_wdata, .reg_rdata,
    .trc_valid, .trc_ready, .trc_data, .trc_trigger
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic push(input logic [31:0] d, input logic trig, output logic acc);
    @(negedge clk);
    trc_valid = 1'b1; trc_data = d; trc_trigger = trig;
    acc = trc_ready;
    @(negedge clk);
    trc_valid = 1'b0; trc_trigger = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R12 ready after reset", 32'(trc_ready), 32'd0);
    rd_chk("R11 depth", OFF_DEPTH, DEPTH);
    rd_chk("R12 ctrl", OFF_CTRL, 0);
    rd_chk("R12 fmtstat stopped", OFF_FMTSTAT, 2);
    rd_chk("R12 status", OFF_STATUS, 0);
    rd_chk("R12 wptr", OFF_WPTR, 0);
    rd_chk("R12 rptr", OFF_RPTR, 0);
    rd_chk("R12 fmtctrl", OFF_FMTCTRL, 0);
  endtask

  task automatic t_sw_port();
    wr(OFF_WPTR, 0);
    for (int i = 0; i < DEPTH; i++) wr(OFF_WDATA, 32'h100 + i);
    rd_chk("R4 wptr wrapped by port writes", OFF_WPTR, 0);
    wr(OFF_RPTR, 0);
    for (int i = 0; i < DEPTH; i++) rd_chk("R5 port read", OFF_RDATA, 32'h100 + i);
    rd_chk("R5 rptr wrapped", OFF_RPTR, 0);
    rd_chk("R3 port writes leave wrapped clear", OFF_STATUS, 0);
  endtask

  task automatic t_capture();
    logic acc;
    wr(OFF_WPTR, 0);
    wr(OFF_CTRL, 1);
    chk("R1 ready after enable", 32'(trc_ready), 1);
    for (int i = 0; i < 6; i++) begin
      push(32'hA0 + i, 1'b0, acc);
      chk("R2 word accepted", 32'(acc), 1);
    end
    rd_chk("R2 wptr after 6", OFF_WPTR, 6);
    wr(OFF_WDATA, 32'hDEAD);
    rd_chk("R4 port write ignored while running", OFF_WPTR, 6);
    wr(OFF_CTRL, 0);
    chk("R1 ready low after disable", 32'(trc_ready), 0);
    idle(1);
    rd_chk("R1 stopped after disable", OFF_FMTSTAT, 2);
    wr(OFF_RPTR, 0);
    for (int i = 0; i < 6; i++) rd_chk("R2 stored word", OFF_RDATA, 32'hA0 + i);
    rd_chk("R5 slot 6 untouched by ignored write", OFF_RDATA, 32'h106);
    rd_chk("R3 no wrap", OFF_STATUS, 0);
  endtask

  task automatic t_wrap();
    logic acc;
    wr(OFF_WPTR, 12);
    wr(OFF_CTRL, 1);
    for (int i = 0; i < 6; i++) push(32'hC0 + i, 1'b0, acc);
    rd_chk("R2 wptr wrapped", OFF_WPTR, 2);
    rd_chk("R3 wrapped flag set", OFF_STATUS, 1);
    wr(OFF_CTRL, 0);
    idle(1);
    wr(OFF_RPTR, 14);
    rd_chk("R2 slot 14", OFF_RDATA, 32'hC2);
    rd_chk("R2 slot 15", OFF_RDATA, 32'hC3);
    rd_chk("R2 slot 0 after wrap", OFF_RDATA, 32'hC4);
    wr(OFF_CTRL, 1);
    rd_chk("R3 restart clears wrapped", OFF_STATUS, 0);
    wr(OFF_CTRL, 0);
    idle(1);
  endtask

  task automatic t_trig_stop();
    logic acc;
    wr(OFF_FMTCTRL, 32'h9);
    wr(OFF_TRIG, 3);
    rd_chk("R11 trig readback", OFF_TRIG, 3);
    wr(OFF_WPTR, 0);
    wr(OFF_CTRL, 1);
    push(32'hD0, 1'b0, acc);
    push(32'hD1, 1'b0, acc);
    push(32'hD2, 1'b1, acc);
    chk("R6 trigger word accepted", 32'(acc), 1);
    for (int i = 3; i < 6; i++) begin
      push(32'hD0 + i, 1'b0, acc);
      chk("R6 post-trigger word accepted", 32'(acc), 1);
    end
    push(32'hD6, 1'b0, acc);
    chk("R6 word after count refused", 32'(acc), 0);
    rd_chk("R6 wptr", OFF_WPTR, 6);
    rd_chk("R7 status seen+done", OFF_STATUS, 6);
    rd_chk("R6 stopped", OFF_FMTSTAT, 2);
    wr(OFF_CTRL, 0);
    idle(1);
  endtask

  task automatic t_trig_count();
    logic acc;
    wr(OFF_FMTCTRL, 32'h1);
    wr(OFF_TRIG, 2);
    wr(OFF_WPTR, 0);
    wr(OFF_CTRL, 1);
    rd_chk("R7 status cleared on start", OFF_STATUS, 0);
    push(32'hE0, 1'b1, acc);
    rd_chk("R7 trigger seen", OFF_STATUS, 2);
    push(32'hE1, 1'b0, acc);
    push(32'hE2, 1'b0, acc);
    rd_chk("R7 count done", OFF_STATUS, 6);
    push(32'hE3, 1'b0, acc);
    push(32'hE4, 1'b0, acc);
    chk("R7 capture continues", 32'(acc), 1);
    rd_chk("R7 wptr", OFF_WPTR, 5);
    wr(OFF_CTRL, 0);
    idle(1);
  endtask

  task automatic t_flush_pad();
    logic acc;
    wr(OFF_FMTCTRL, 32'h5);
    wr(OFF_WPTR, 0);
    wr(OFF_CTRL, 1);
    for (int i = 0; i < 5; i++) push(32'hF0 + i, 1'b0, acc);
    wr(OFF_FMTCTRL, 32'h7);
    chk("R8 ready held off by flush", 32'(trc_ready), 0);
    idle(6);
    rd_chk("R8 flush bit self-cleared", OFF_FMTCTRL, 5);
    rd_chk("R10 stopped after flush", OFF_FMTSTAT, 2);
    rd_chk("R8 wptr on frame boundary", OFF_WPTR, 8);
    chk("R10 ready low", 32'(trc_ready), 0);
    wr(OFF_CTRL, 0);
    idle(1);
    wr(OFF_RPTR, 4);
    rd_chk("R8 last data word", OFF_RDATA, 32'hF4);
    for (int i = 5; i < 8; i++) rd_chk("R8 pad word zero", OFF_RDATA, 0);
  endtask

  task automatic t_flush_nofmt();
    logic acc;
    wr(OFF_FMTCTRL, 0);
    wr(OFF_WPTR, 0);
    wr(OFF_CTRL, 1);
    for (int i = 0; i < 3; i++) push(32'h70 + i, 1'b0, acc);
    wr(OFF_FMTCTRL, 32'h2);
    idle(3);
    rd_chk("R9 flush cleared", OFF_FMTCTRL, 0);
    rd_chk("R9 no padding", OFF_WPTR, 3);
    chk("R10 capture resumes without stop option", 32'(trc_ready), 1);
    wr(OFF_CTRL, 0);
    idle(1);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sw_port();
    t_capture();
    t_wrap();
    t_trig_stop();
    t_trig_count();
    t_flush_pad();
    t_flush_nofmt();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule